// File: doc/BRIEF.md
# Iterative Square Root Convergence Unit

The unit takes an unsigned fixed-point operand in Q2.F format (two integer bits, F fraction bits) and returns its square root, rounded to nearest, in the same Q2.F format. Callers normalise the operand to [1.0, 4.0) before handing it over. Internally the unit keeps three quantities in signed fixed point with extra guard bits: a root estimate, a drive value that moves toward 1.0, and an explicit error term equal to 1 minus the drive.

The unit first picks a coarse reciprocal-square-root seed y0 from one of four operand sub-ranges. It then sets root = x*y0, drive = x*y0*y0 and error = 1 - drive. On each pass it forms one shared correction factor c = 1 + error/2. It multiplies the root by c and the drive by c twice, then recomputes the error. When the error magnitude falls below 2^-F the passes stop. Three short square-and-compare steps then adjust the truncated root by at most one ulp in each direction, and round it to nearest. If convergence never arrives, a hard pass limit ends the run and flags a timeout.

Operands arrive on a valid/ready input channel, and the unit holds one operand at a time. `in_ready` is high only while idle, and a transfer happens on a clock edge where `in_valid` and `in_ready` are both high. Results leave on a valid/ready output channel. `out_valid` stays high, and `out_root` and `out_timeout` stay unchanged, until the edge where `out_ready` is high. A caller that keeps `out_ready` high therefore sees a one-cycle completion pulse.

Top module: `sqrt_gs_unit`

## Requirements
- R1: Out of reset, `in_ready` is 1 and `out_valid` is 0.
- R2: An operand is taken on an edge where `in_valid` and `in_ready` are both 1. From that edge until the result has been handed over, `in_ready` is 0.
- R3: A request presented while the unit is busy (`in_ready` = 0) is ignored. It yields no result, and the pending result is unaffected.
- R4: For an operand x in [1.0, 4.0) given as Q2.F (value = in_operand / 2^F), `out_root` equals sqrt(x)*2^F rounded to the nearest integer, in Q2.F, with `out_timeout` = 0.
- R5: Operands that are exact squares in Q2.F (such as 1.0, 1.5625, 2.25) return the exact root with no rounding error.
- R6: The largest operand (all ones, just under 4.0) returns 2.0 (`out_root` = 2^(F+1)), because the true root lies less than half an ulp below 2.0.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_root` and `out_timeout` do not change.
- R8: A result is handed over on an edge where `out_valid` and `out_ready` are both 1. On the next cycle `out_valid` is 0, so with `out_ready` held at 1 the completion is a one-cycle pulse.
- R9: Passes stop as soon as the error magnitude is below 2^-F. A converging operand produces its result at most MAX_PASS+5 cycles after the accepting edge.
- R10: If the error never drops below the threshold (for example operand 0), the unit stops after MAX_PASS passes. The result then appears exactly MAX_PASS+2 cycles after the accepting edge, with `out_timeout` = 1 and the truncated root, which is 0 for operand 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle and able to take an operand |
| in_operand | input | FRAC_W+2 | Operand, unsigned Q2.F |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_root | output | FRAC_W+2 | Rounded square root, unsigned Q2.F |
| out_timeout | output | 1 | Pass limit reached without convergence |

## Verification
Operands are chosen from all four seed sub-ranges. Exact squares show whether the fix-up steps leave a correct root alone, and the extreme operands 1.0+ulp and all-ones test the edges of the range and the carry into 2.0. A stream of pseudo-random operands, each checked against an integer square root computed in the bench, catches truncation or correction errors that occur only for some operands. Operand 0 never converges, which separates the threshold exit from the pass-limit exit by latency and by the timeout flag. Requests made while busy, and results held back by a low `out_ready`, test both handshake rules.

// File: rtl/sqrt_gs_pkg.sv
package sqrt_gs_pkg;

  // Controller sequence: seed, converge, two one-ulp fix-ups, round, hand over.
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_SEED  = 3'd1,
    S_ITER  = 3'd2,
    S_FIXDN = 3'd3,
    S_FIXUP = 3'd4,
    S_RND   = 3'd5,
    S_OUT   = 3'd6
  } gs_state_e;

endpackage

// File: rtl/gs_seed_stage.sv
module gs_seed_stage #(
  parameter int FRAC_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic [FRAC_W+1:0]                   op_i,
  output logic signed [FRAC_W+GUARD_W+3:0]    root0_o,
  output logic signed [FRAC_W+GUARD_W+3:0]    drive0_o,
  output logic signed [FRAC_W+GUARD_W+3:0]    err0_o
);
  localparam int FI = FRAC_W + GUARD_W;
  localparam int IW = FI + 4;
  localparam logic signed [IW-1:0] ONE_Q = IW'(1) <<< FI;

  // 1/sqrt of each sub-range midpoint (1.25, 1.75, 2.5, 3.5) in Q0.16
  localparam int unsigned SEED_Q16 [4] = '{58617, 49540, 41449, 35030};

  function automatic logic signed [IW-1:0] mulq(input logic signed [IW-1:0] a,
                                                input logic signed [IW-1:0] b);
    logic signed [2*IW-1:0] p;
    p = a * b;
    return p[FI +: IW];
  endfunction

  logic [1:0]             idx;
  logic [IW-1:0]          seed_raw;
  logic signed [IW-1:0]   y0;
  logic signed [IW-1:0]   op_ext;

  // sub-ranges [1,1.5) [1.5,2) [2,3) [3,4)
  assign idx      = op_i[FRAC_W+1] ? {1'b1, op_i[FRAC_W]} : {1'b0, op_i[FRAC_W-1]};
  assign seed_raw = IW'(SEED_Q16[idx]);

  generate
    if (FI >= 16) begin : g_seed_up
      assign y0 = signed'(seed_raw << (FI - 16));
    end else begin : g_seed_dn
      assign y0 = signed'(seed_raw >> (16 - FI));
    end
  endgenerate

  assign op_ext   = signed'({2'b00, op_i, {GUARD_W{1'b0}}});
  assign root0_o  = mulq(op_ext, y0);
  assign drive0_o = mulq(root0_o, y0);
  assign err0_o   = ONE_Q - drive0_o;

endmodule

// File: rtl/gs_pass_stage.sv
module gs_pass_stage #(
  parameter int FRAC_W  = 16,
  parameter int GUARD_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                en_i,
  input  logic signed [FRAC_W+GUARD_W+3:0]    root_i,
  input  logic signed [FRAC_W+GUARD_W+3:0]    drive_i,
  input  logic signed [FRAC_W+GUARD_W+3:0]    err_i,
  output logic signed [FRAC_W+GUARD_W+3:0]    root_o,
  output logic signed [FRAC_W+GUARD_W+3:0]    drive_o,
  output logic signed [FRAC_W+GUARD_W+3:0]    err_o,
  output logic                                conv_o
);
  localparam int FI = FRAC_W + GUARD_W;
  localparam int IW = FI + 4;
  localparam logic signed [IW-1:0] ONE_Q   = IW'(1) <<< FI;
  localparam logic        [IW-1:0] THR_Q   = IW'(1) << GUARD_W;
  localparam logic        [IW-1:0] QUART_Q = IW'(1) << (FI - 2);

  function automatic logic signed [IW-1:0] mulq(input logic signed [IW-1:0] a,
                                                input logic signed [IW-1:0] b);
    logic signed [2*IW-1:0] p;
    p = a * b;
    return p[FI +: IW];
  endfunction

  logic signed [IW-1:0] corr;
  logic signed [IW-1:0] drive_c;
  logic        [IW-1:0] mag_in;
  logic        [IW-1:0] mag_out;

  // one shared factor for root and drive
  assign corr    = ONE_Q + (err_i >>> 1);
  assign root_o  = mulq(root_i, corr);
  assign drive_c = mulq(drive_i, corr);
  assign drive_o = mulq(drive_c, corr);
  assign err_o   = ONE_Q - drive_o;

  assign mag_in  = err_i[IW-1] ? $unsigned(-err_i) : $unsigned(err_i);
  assign mag_out = err_o[IW-1] ? $unsigned(-err_o) : $unsigned(err_o);
  assign conv_o  = mag_in < THR_Q;

  // R9: a pass on an unconverged, small error must shrink it
  err_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !conv_o && mag_in < QUART_Q) |-> (mag_out < mag_in));

endmodule

// File: rtl/gs_round_unit.sv
module gs_round_unit #(
  parameter int FRAC_W = 16
) (
  input  logic [FRAC_W+1:0]   t_i,
  input  logic [2*FRAC_W+1:0] n_i,
  output logic                over_o,
  output logic                under_o,
  output logic                half_up_o
);
  localparam int RW  = FRAC_W + 2;
  localparam int SQW = 2 * RW + 2;

  logic [SQW-1:0] te, tp, th, ne, ne4;

  assign te  = SQW'(t_i);
  assign tp  = te + SQW'(1);
  assign th  = (te << 1) + SQW'(1);
  assign ne  = SQW'(n_i);
  assign ne4 = ne << 2;

  assign over_o    = (te * te) > ne;   // t too large
  assign under_o   = (tp * tp) <= ne;  // t+1 still fits
  assign half_up_o = (th * th) < ne4;  // root lies above t + 1/2

endmodule

// File: rtl/sqrt_gs_unit.sv
module sqrt_gs_unit
  import sqrt_gs_pkg::*;
#(
  parameter int FRAC_W   = 16,
  parameter int GUARD_W  = 8,
  parameter int MAX_PASS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [FRAC_W+1:0]   in_operand,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [FRAC_W+1:0]   out_root,
  output logic                out_timeout
);
  localparam int OPW = FRAC_W + 2;
  localparam int FI  = FRAC_W + GUARD_W;
  localparam int IW  = FI + 4;
  localparam int NW  = 2 * FRAC_W + 2;
  localparam int CW  = $clog2(MAX_PASS + 1);
  localparam int SQW = 2 * OPW + 2;

  gs_state_e            state_q;
  logic [OPW-1:0]       op_q;
  logic signed [IW-1:0] root_q, drive_q, err_q;
  logic [CW-1:0]        pass_q;
  logic [OPW-1:0]       t_q;
  logic                 tmo_q;

  logic signed [IW-1:0] root0, drive0, err0;
  logic signed [IW-1:0] root_n, drive_n, err_n;
  logic                 conv;
  logic [NW-1:0]        n_val;
  logic                 over, under, half_up;

  assign n_val = {op_q, {FRAC_W{1'b0}}};

  gs_seed_stage #(.FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) seed_i (
    .op_i(op_q), .root0_o(root0), .drive0_o(drive0), .err0_o(err0)
  );

  gs_pass_stage #(.FRAC_W(FRAC_W), .GUARD_W(GUARD_W)) pass_i (
    .clk(clk), .rst_n(rst_n), .en_i(state_q == S_ITER),
    .root_i(root_q), .drive_i(drive_q), .err_i(err_q),
    .root_o(root_n), .drive_o(drive_n), .err_o(err_n), .conv_o(conv)
  );

  gs_round_unit #(.FRAC_W(FRAC_W)) rnd_i (
    .t_i(t_q), .n_i(n_val), .over_o(over), .under_o(under), .half_up_o(half_up)
  );

  assign in_ready    = (state_q == S_IDLE);
  assign out_valid   = (state_q == S_OUT);
  assign out_root    = t_q;
  assign out_timeout = tmo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      op_q    <= '0;
      root_q  <= '0;
      drive_q <= '0;
      err_q   <= '0;
      pass_q  <= '0;
      t_q     <= '0;
      tmo_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (in_valid) begin
          op_q    <= in_operand;
          tmo_q   <= 1'b0;
          state_q <= S_SEED;
        end
        S_SEED: begin
          root_q  <= root0;
          drive_q <= drive0;
          err_q   <= err0;
          pass_q  <= '0;
          state_q <= S_ITER;
        end
        S_ITER: begin
          if (conv) begin
            t_q     <= root_q[GUARD_W +: OPW];
            state_q <= S_FIXDN;
          end else if (pass_q == CW'(MAX_PASS)) begin
            t_q     <= root_q[GUARD_W +: OPW];
            tmo_q   <= 1'b1;
            state_q <= S_OUT;
          end else begin
            root_q  <= root_n;
            drive_q <= drive_n;
            err_q   <= err_n;
            pass_q  <= pass_q + CW'(1);
          end
        end
        S_FIXDN: begin
          if (over) t_q <= t_q - OPW'(1);
          state_q <= S_FIXUP;
        end
        S_FIXUP: begin
          if (under) t_q <= t_q + OPW'(1);
          state_q <= S_RND;
        end
        S_RND: begin
          if (half_up) t_q <= t_q + OPW'(1);
          state_q <= S_OUT;
        end
        S_OUT: if (out_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // bounds of the rounding interval, used only by the checks below
  logic [SQW-1:0] chk_lo, chk_hi, chk_n4;
  assign chk_lo = ((SQW'(out_root) << 1) - SQW'(1)) * ((SQW'(out_root) << 1) - SQW'(1));
  assign chk_hi = ((SQW'(out_root) << 1) + SQW'(1)) * ((SQW'(out_root) << 1) + SQW'(1));
  assign chk_n4 = SQW'(n_val) << 2;

  // R7
  hold_under_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_root) && $stable(out_timeout)));

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  // R9
  pass_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ITER) |-> (pass_q <= CW'(MAX_PASS)));

  // R4
  round_nearest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_timeout && op_q[OPW-1 -: 2] != 2'b00)
      |-> (chk_lo <= chk_n4 && chk_n4 < chk_hi));

  // R10
  zero_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && op_q == '0) |-> (out_timeout && out_root == '0));

endmodule

// File: tb/sqrt_gs_unit_tb_top.sv
`timescale 1ns/1ps
module sqrt_gs_unit_tb_top;
  localparam int F    = 16;
  localparam int MAXP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [F+1:0] in_operand = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [F+1:0] out_root;
  logic out_timeout;

  always #10 clk = ~clk;  // 50 MHz

  sqrt_gs_unit #(.FRAC_W(F), .GUARD_W(8), .MAX_PASS(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .out_valid(out_valid), .out_ready(out_ready),
    .out_root(out_root), .out_timeout(out_timeout)
  );

  typedef struct {
    longint root;
    bit     tmo;
    string  req;
  } exp_t;

  exp_t   sb_q[$];
  int     n_tests = 0;
  int     n_fail  = 0;
  longint cyc = 0;
  longint accept_cyc = 0;
  bit     done_flag = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic longint ref_root(input longint op);
    longint n, r, t;
    n = op << F;
    r = 0;
    for (int b = 20; b >= 0; b--) begin
      t = r | (longint'(1) << b);
      if (t * t <= n) r = t;
    end
    if ((2*r + 1) * (2*r + 1) < 4*n) r = r + 1;
    return r;
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // driver: push expected item, offer operand until taken
  task automatic send(input longint op, input string req, input bit tmo);
    exp_t e;
    @(negedge clk);
    in_valid   = 1'b1;
    in_operand = op[F+1:0];
    while (!in_ready) @(negedge clk);
    accept_cyc = cyc + 1;
    e.root = tmo ? 0 : ref_root(op);
    e.tmo  = tmo;
    e.req  = req;
    sb_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R2", "in_ready after take", longint'(in_ready), 0);
  endtask

  task automatic drain();
    int k = 0;
    while (sb_q.size() != 0 && k < 400) begin
      @(negedge clk);
      k++;
    end
    chk(sb_q.size() == 0, "R4", "result outstanding", sb_q.size(), 0);
  endtask

  // monitor / scoreboard
  bit           prev_valid = 1'b0;
  bit           prev_xfer  = 1'b0;
  logic [F+1:0] prev_root  = '0;
  bit           prev_tmo   = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_xfer)
        chk(!out_valid, "R8", "out_valid after handover", longint'(out_valid), 0);
      if (prev_valid && !prev_xfer)
        chk(out_valid && out_root == prev_root && out_timeout == prev_tmo,
            "R7", "held result", longint'(out_root), longint'(prev_root));
      if (out_valid && !prev_valid && sb_q.size() != 0) begin
        if (sb_q[0].tmo)
          chk(cyc - accept_cyc == MAXP + 2, "R10", "timeout latency",
              cyc - accept_cyc, MAXP + 2);
        else
          chk(cyc - accept_cyc <= MAXP + 5, "R9", "latency bound",
              cyc - accept_cyc, MAXP + 5);
      end
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected result", longint'(out_root), -1);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(longint'(out_root) == e.root, e.req, "root", longint'(out_root), e.root);
          chk(out_timeout == e.tmo, e.req, "timeout flag",
              longint'(out_timeout), longint'(e.tmo));
        end
      end
      prev_valid = out_valid;
      prev_xfer  = out_valid && out_ready;
      prev_root  = out_root;
      prev_tmo   = out_timeout;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R1
    chk(in_ready == 1'b1, "R1", "in_ready in reset", longint'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "idle after reset",
        longint'(in_ready), 1);

    // R5 exact squares
    send(65536,  "R5", 1'b0); drain();   // 1.0    -> 1.0
    send(102400, "R5", 1'b0); drain();   // 1.5625 -> 1.25
    send(147456, "R5", 1'b0); drain();   // 2.25   -> 1.5
    send(200704, "R5", 1'b0); drain();   // 3.0625 -> 1.75

    // R4 one per seed sub-range and range edges
    send(65537,  "R4", 1'b0); drain();
    send(110000, "R4", 1'b0); drain();
    send(131072, "R4", 1'b0); drain();
    send(196608, "R4", 1'b0); drain();
    send(240000, "R4", 1'b0); drain();

    // R6 top of range
    send(262143, "R6", 1'b0); drain();

    // R4 pseudo-random operands across [1,4)
    lfsr = 32'hACE1_2B57;
    for (int i = 0; i < 24; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      send(65536 + longint'(lfsr % 196608), "R4", 1'b0);
      drain();
    end

    // R7 back-pressure
    out_ready = 1'b0;
    send(170000, "R7", 1'b0);
    repeat (30) @(negedge clk);
    chk(out_valid == 1'b1, "R7", "valid held", longint'(out_valid), 1);
    out_ready = 1'b1;
    drain();

    // R3 requests while busy are ignored
    send(90000, "R3", 1'b0);
    for (int k = 0; k < 4; k++) begin
      in_valid   = 1'b1;
      in_operand = 18'd250000;
      chk(!in_ready, "R3", "in_ready while busy", longint'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    drain();
    repeat (20) @(negedge clk);
    chk(sb_q.size() == 0 && !out_valid, "R3", "no extra result",
        longint'(out_valid), 0);

    // R10 operand zero never converges
    send(0, "R10", 1'b1); drain();

    // R4 normal operation after a timeout
    send(123456, "R4", 1'b0); drain();

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule